// File: doc/BRIEF.md
# Threshold-Gated Packet Receive FIFO

This block sits between the receive side of an Ethernet MAC and a DMA engine. The MAC writes one 64-bit word per beat. Each word carries a start-of-packet flag, an end-of-packet flag and a vector of error-class flags. The DMA side reads words through a valid/ready handshake. Each word it reads carries end-of-packet and error status. A separate data-available request tells the DMA engine when a block transfer is worth starting.

Each new packet stays hidden from the read side until a programmable number of its words, the release threshold, has been written. If the packet ends before that point, it becomes visible at once. While a packet is hidden, an error can discard it. The write position rewinds to the packet start, so the read side never sees any part of that packet.

A global drop-all control, together with a per-class drop mask, decides whether an early error drops the packet or lets it through. A packet that is let through, or that fails after its release, is delivered with error status on its last word. Once a packet is visible, the request asserts when enough words are waiting to reach the read threshold, or when a complete packet end is waiting. Every error, and every overflow, produces a one-cycle pulse for external statistics counters.

Top module: `rxGateFifo`

## Requirements
- R1: After reset, rdValid, dmaReq and errEvent are all 0.
- R2: For a packet whose words carry no error, rdValid stays 0 until the write of the packet's cfgRelThresh-th word, counting from the start-of-packet word. From the cycle after that write, all of the packet's words written so far are readable.
- R3: If the end-of-packet word is written before the release threshold is reached, the packet becomes readable in the cycle after that write.
- R4: dmaReq is 1 when the number of readable words is at least cfgRdThresh. When no end-of-packet word is readable and fewer than cfgRdThresh words are readable, dmaReq is 0.
- R5: When at least one readable word has its end-of-packet flag set, dmaReq is 1 whatever the value of cfgRdThresh.
- R6: A word carrying an error, written while its packet is still hidden, discards the packet when the drop rule of R7 applies. The discard covers the word that would have released the packet. The read side then sees none of the packet, and the next packet is delivered normally.
- R7: Bit i of wrErr flags error class i. An error is droppable when cfgDropAll is 1, or when wrErr AND cfgDropMask is nonzero. A non-droppable early error is stored, and the packet is delivered with rdErr=1 on its end-of-packet word.
- R8: An error on a word written after its packet's release is never dropped, even with cfgDropAll=1. The whole packet is delivered, and its end-of-packet word reads with rdErr=1.
- R9: errEvent is 1 for exactly the one cycle after each accepted errored write, whether the packet is dropped or delivered, and after each overflow.
- R10: A write of a packet word while 64 words (DEPTH) are stored is an overflow. If the packet is still hidden, the packet is discarded.
- R11: An overflow on a released packet truncates it. The last stored word becomes its end with rdEop=1 and rdErr=1. Later words are discarded until the next start-of-packet.
- R12: Each cycle with rdValid=1 and rdReady=1 delivers one word, in write order. While rdValid=1 and rdReady=0, rdData is held.
- R13: A word written with wrSop=0 when no packet is open is ignored. It is not stored and raises no errEvent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write beat present |
| wrData | input | 64 | Write data word |
| wrSop | input | 1 | Word starts a packet |
| wrEop | input | 1 | Word ends a packet |
| wrErr | input | 4 | Error-class flags for this word |
| cfgRelThresh | input | 7 | Words needed to release a new packet |
| cfgRdThresh | input | 7 | Readable words needed to raise dmaReq |
| cfgDropAll | input | 1 | Drop every packet with an early error |
| cfgDropMask | input | 4 | Error classes that are dropped early |
| rdValid | output | 1 | A readable word is presented |
| rdReady | input | 1 | Read side accepts the word |
| rdData | output | 64 | Read data word |
| rdEop | output | 1 | Presented word ends a packet |
| rdErr | output | 1 | Presented packet end carries error status |
| dmaReq | output | 1 | Data-available request to the DMA engine |
| errEvent | output | 1 | One-cycle error pulse for statistics |

## Verification
The hardest situations to reach from the ports are the two overflow outcomes. The first is an overflow on a packet that is still hidden, which must roll back a full buffer of 64 words. The second is an overflow on a released packet, which must rewrite the status of its newest stored word. To reach them, the stimulus holds rdReady low and streams 65 words of one packet. The release threshold is set above 64 to keep the packet hidden, or to 2 to release it early. After the truncating overflow, the bench writes extra trailing words before it drains the buffer, to show that they are discarded. Drop decisions exactly at the release boundary are reached by placing the error on the word that would itself have released the packet.

// File: rtl/rxgf_pkg.sv
package rxgf_pkg;

  // Packet tracking state on the write side.
  typedef enum logic [1:0] {
    PKT_IDLE   = 2'd0,  // no open packet; non-start words are ignored
    PKT_HIDDEN = 2'd1,  // packet open but not yet visible to the reader
    PKT_OPEN   = 2'd2   // packet released; words become visible as written
  } pktState_e;

  // Strobes from control to the datapath.
  typedef struct packed {
    logic wrEn;     // store a word at wrAddr
    logic patchEn;  // mark the word at patchAddr as errored packet end
    logic eop;      // end flag for the stored word
    logic err;      // error flag for the stored word
  } dpStrobe_t;

endpackage

// File: rtl/rxgfStore.sv
module rxgfStore
  import rxgf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] patchAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEop,
  output logic              rdErr
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  eopBits;
  logic [DEPTH-1:0]  errBits;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      mem[wrAddr]     <= wrData;
      eopBits[wrAddr] <= strobe.eop;
      errBits[wrAddr] <= strobe.err;
    end
    if (strobe.patchEn) begin
      eopBits[patchAddr] <= 1'b1;
      errBits[patchAddr] <= 1'b1;
    end
  end

  assign rdData = mem[rdAddr];
  assign rdEop  = eopBits[rdAddr];
  assign rdErr  = errBits[rdAddr];

  // A store and a truncation patch never coincide.
  AST_WR_PATCH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.patchEn)); // R11

endmodule

// File: rtl/rxgfCtrl.sv
module rxgfCtrl
  import rxgf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int NUM_ERR = 4,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  input  logic               wrSop,
  input  logic               wrEop,
  input  logic [NUM_ERR-1:0] wrErr,
  input  logic [CNT_W-1:0]   cfgRelThresh,
  input  logic [CNT_W-1:0]   cfgRdThresh,
  input  logic               cfgDropAll,
  input  logic [NUM_ERR-1:0] cfgDropMask,
  input  logic               rdReady,
  input  logic               rdEop,
  output logic               rdValid,
  output logic               dmaReq,
  output logic               errEvent,
  output dpStrobe_t          strobe,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [ADDR_W-1:0]  patchAddr,
  output logic [ADDR_W-1:0]  rdAddr
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  pktState_e        state, stateNext;
  logic [CNT_W-1:0] workPtr, workNext;     // next free slot, includes hidden words
  logic [CNT_W-1:0] commitPtr, commitNext; // end of the visible region
  logic [CNT_W-1:0] rdPtr;
  logic [CNT_W-1:0] pktCnt, pktCntNext;    // words stored for the open packet
  logic             pktErr, pktErrNext;    // sticky error of the open packet
  logic [CNT_W-1:0] eopCount;              // visible words with end flag
  logic             errNext;
  logic             eopInc;

  logic [CNT_W-1:0] basePtr, cntNow, cntInc, visCount;
  logic             hidden, inPkt, fullNow, errHit, dropSel, releaseNow, stickyNow;
  logic             rdFire;

  // Decode of the incoming beat against the packet state.
  always_comb begin
    basePtr    = wrSop ? commitPtr : workPtr;  // a new start abandons a hidden remnant
    hidden     = wrSop || (state == PKT_HIDDEN);
    inPkt      = wrSop || (state != PKT_IDLE);
    cntNow     = wrSop ? '0 : pktCnt;
    stickyNow  = wrSop ? 1'b0 : pktErr;
    cntInc     = (cntNow == CNT_MAX) ? cntNow : cntNow + 1'b1;
    fullNow    = ((basePtr - rdPtr) == FULL_CNT);
    errHit     = |wrErr;
    dropSel    = cfgDropAll || (|(wrErr & cfgDropMask));
    releaseNow = wrEop || (cntInc >= cfgRelThresh);
  end

  // Next-state logic of the write side.
  always_comb begin
    stateNext  = state;
    workNext   = workPtr;
    commitNext = commitPtr;
    pktCntNext = pktCnt;
    pktErrNext = pktErr;
    errNext    = 1'b0;
    eopInc     = 1'b0;
    strobe     = '0;
    if (wrValid && inPkt) begin
      if (fullNow) begin
        errNext   = 1'b1;
        stateNext = PKT_IDLE;
        if (hidden) begin
          workNext = commitPtr;
        end else begin
          strobe.patchEn = 1'b1;
          eopInc         = 1'b1;
        end
      end else if (hidden && errHit && dropSel) begin
        errNext   = 1'b1;
        workNext  = commitPtr;
        stateNext = PKT_IDLE;
      end else begin
        strobe.wrEn = 1'b1;
        strobe.eop  = wrEop;
        strobe.err  = wrEop && (stickyNow || errHit);
        workNext    = basePtr + 1'b1;
        errNext     = errHit;
        pktCntNext  = cntInc;
        pktErrNext  = stickyNow || errHit;
        if (!hidden || releaseNow) begin
          commitNext = basePtr + 1'b1;
          eopInc     = wrEop;
        end
        if (wrEop) begin
          stateNext = PKT_IDLE;
        end else if (!hidden || releaseNow) begin
          stateNext = PKT_OPEN;
        end else begin
          stateNext = PKT_HIDDEN;
        end
      end
    end
  end

  assign visCount  = commitPtr - rdPtr;
  assign rdValid   = (commitPtr != rdPtr);
  assign rdFire    = rdValid && rdReady;
  assign dmaReq    = rdValid && ((visCount >= cfgRdThresh) || (eopCount != '0));
  assign wrAddr    = basePtr[ADDR_W-1:0];
  assign patchAddr = ADDR_W'(workPtr - 1'b1);
  assign rdAddr    = rdPtr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= PKT_IDLE;
      workPtr   <= '0;
      commitPtr <= '0;
      rdPtr     <= '0;
      pktCnt    <= '0;
      pktErr    <= 1'b0;
      eopCount  <= '0;
      errEvent  <= 1'b0;
    end else begin
      state     <= stateNext;
      workPtr   <= workNext;
      commitPtr <= commitNext;
      rdPtr     <= rdPtr + CNT_W'(rdFire);
      pktCnt    <= pktCntNext;
      pktErr    <= pktErrNext;
      eopCount  <= eopCount + CNT_W'(eopInc) - CNT_W'(rdFire && rdEop);
      errEvent  <= errNext;
    end
  end

  // Occupancy never exceeds the storage depth.
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (workPtr - rdPtr) <= FULL_CNT); // R10

  // The visible region lies inside the written region.
  AST_VISIBLE_INSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (commitPtr - rdPtr) <= (workPtr - rdPtr)); // R2

  // A hidden packet always holds at least one unreleased word.
  AST_HIDDEN_HAS_WORDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == PKT_HIDDEN) |-> (workPtr != commitPtr)); // R6

  // Visible end markers are bounded by visible words.
  AST_EOP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    eopCount <= (commitPtr - rdPtr)); // R5

  // An error pulse always follows a write beat.
  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    errEvent |-> $past(wrValid)); // R9

endmodule

// File: rtl/rxGateFifo.sv
module rxGateFifo
  import rxgf_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int DEPTH   = 64,
  parameter int NUM_ERR = 4,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               wrSop,
  input  logic               wrEop,
  input  logic [NUM_ERR-1:0] wrErr,
  input  logic [CNT_W-1:0]   cfgRelThresh,
  input  logic [CNT_W-1:0]   cfgRdThresh,
  input  logic               cfgDropAll,
  input  logic [NUM_ERR-1:0] cfgDropMask,
  output logic               rdValid,
  input  logic               rdReady,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdEop,
  output logic               rdErr,
  output logic               dmaReq,
  output logic               errEvent
);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] wrAddr, patchAddr, rdAddr;

  rxgfCtrl #(.DEPTH(DEPTH), .NUM_ERR(NUM_ERR)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrSop(wrSop), .wrEop(wrEop), .wrErr(wrErr),
    .cfgRelThresh(cfgRelThresh), .cfgRdThresh(cfgRdThresh),
    .cfgDropAll(cfgDropAll), .cfgDropMask(cfgDropMask),
    .rdReady(rdReady), .rdEop(rdEop),
    .rdValid(rdValid), .dmaReq(dmaReq), .errEvent(errEvent),
    .strobe(strobe), .wrAddr(wrAddr), .patchAddr(patchAddr), .rdAddr(rdAddr)
  );

  rxgfStore #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .patchAddr(patchAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .rdEop(rdEop), .rdErr(rdErr)
  );

  // A stalled word stays presented and unchanged.
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData))); // R12

endmodule

// File: tb/rxGateFifo_tb.sv
module rxGateFifo_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0, wrSop = 1'b0, wrEop = 1'b0;
  logic [63:0] wrData = '0;
  logic [3:0]  wrErr = '0;
  logic [6:0]  cfgRelThresh = 7'd8, cfgRdThresh = 7'd4;
  logic        cfgDropAll = 1'b0;
  logic [3:0]  cfgDropMask = '0;
  logic        rdReady = 1'b0;
  logic        rdValid, rdEop, rdErr, dmaReq, errEvent;
  logic [63:0] rdData;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rxGateFifo u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .wrSop(wrSop), .wrEop(wrEop), .wrErr(wrErr),
    .cfgRelThresh(cfgRelThresh), .cfgRdThresh(cfgRdThresh),
    .cfgDropAll(cfgDropAll), .cfgDropMask(cfgDropMask),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
    .rdEop(rdEop), .rdErr(rdErr), .dmaReq(dmaReq), .errEvent(errEvent)
  );

  typedef struct packed {
    logic [6:0] rel;
    logic [6:0] rd;
    logic [6:0] len;
    logic [6:0] errAt;   // 127: no error
    logic [3:0] errCls;
    logic       dropAll;
    logic [3:0] mask;
    logic [6:0] expCnt;
    logic       expErr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{7'd8, 7'd4, 7'd10, 7'd127, 4'b0000, 1'b0, 4'b0000, 7'd10, 1'b0}, // R2
    '{7'd8, 7'd4, 7'd3,  7'd127, 4'b0000, 1'b0, 4'b0000, 7'd3,  1'b0}, // R3
    '{7'd8, 7'd4, 7'd10, 7'd2,   4'b0001, 1'b1, 4'b0000, 7'd0,  1'b0}, // R6
    '{7'd8, 7'd4, 7'd10, 7'd2,   4'b0010, 1'b0, 4'b0010, 7'd0,  1'b0}, // R7 mask drop
    '{7'd8, 7'd4, 7'd10, 7'd2,   4'b0010, 1'b0, 4'b0001, 7'd10, 1'b1}, // R7 deliver
    '{7'd8, 7'd4, 7'd10, 7'd9,   4'b0001, 1'b1, 4'b0000, 7'd10, 1'b1}, // R8
    '{7'd4, 7'd4, 7'd6,  7'd3,   4'b0001, 1'b1, 4'b0000, 7'd0,  1'b0}, // R6 boundary
    '{7'd4, 7'd4, 7'd6,  7'd4,   4'b0001, 1'b1, 4'b0000, 7'd6,  1'b1}, // R8 boundary
    '{7'd8, 7'd4, 7'd4,  7'd3,   4'b0100, 1'b1, 4'b0000, 7'd0,  1'b0}, // R6 runt
    '{7'd2, 7'd4, 7'd5,  7'd0,   4'b1000, 1'b0, 4'b0111, 7'd5,  1'b1}  // R7 error on start
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic putWord(input int pid, input int idx, input bit sop, input bit eop, input logic [3:0] err);
    wrValid = 1'b1;
    wrSop   = sop;
    wrEop   = eop;
    wrErr   = err;
    wrData  = {32'(pid), 32'(idx)};
    @(negedge clk);
    wrValid = 1'b0;
    wrSop   = 1'b0;
    wrEop   = 1'b0;
    wrErr   = '0;
  endtask

  task automatic drain(input int pid, output int n, output logic lastEop, output logic lastErr, output bit orderOk);
    n = 0;
    lastEop = 1'b0;
    lastErr = 1'b0;
    orderOk = 1'b1;
    rdReady = 1'b1;
    while (rdValid && n < 200) begin
      if (rdData != {32'(pid), 32'(n)}) orderOk = 1'b0;
      lastEop = rdEop;
      lastErr = rdErr;
      n++;
      @(negedge clk);
    end
    rdReady = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        summary();
      end
    end
  end

  initial begin
    int n;
    logic le, lr;
    bit ok;
    logic [63:0] held;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(rdValid == 0, "R1 rdValid", 64'(rdValid), 0);
    check(dmaReq == 0, "R1 dmaReq", 64'(dmaReq), 0);
    check(errEvent == 0, "R1 errEvent", 64'(errEvent), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table-driven packets
    for (int v = 0; v < NV; v++) begin
      cfgRelThresh = VECS[v].rel;
      cfgRdThresh  = VECS[v].rd;
      cfgDropAll   = VECS[v].dropAll;
      cfgDropMask  = VECS[v].mask;
      for (int i = 0; i < int'(VECS[v].len); i++) begin
        putWord(v, i, i == 0, i == int'(VECS[v].len) - 1,
                (i == int'(VECS[v].errAt)) ? VECS[v].errCls : 4'b0000);
        if (i == int'(VECS[v].errAt))
          check(errEvent == 1, $sformatf("R9 vec%0d", v), 64'(errEvent), 1);
        else
          check(errEvent == 0, $sformatf("R9 vec%0d quiet", v), 64'(errEvent), 0);
        if (i == int'(VECS[v].errAt) && VECS[v].expCnt == 0) break;
      end
      check(rdValid == (VECS[v].expCnt != 0), $sformatf("R6 vec%0d visible", v),
            64'(rdValid), 64'(VECS[v].expCnt != 0));
      check(dmaReq == (VECS[v].expCnt != 0), $sformatf("R5 vec%0d req", v),
            64'(dmaReq), 64'(VECS[v].expCnt != 0));
      drain(v, n, le, lr, ok);
      check(n == int'(VECS[v].expCnt), $sformatf("R7 vec%0d count", v), 64'(n), 64'(VECS[v].expCnt));
      check(ok, $sformatf("R12 vec%0d order", v), 64'(ok), 1);
      if (VECS[v].expCnt != 0) begin
        check(le == 1, $sformatf("R8 vec%0d eop", v), 64'(le), 1);
        check(lr == VECS[v].expErr, $sformatf("R8 vec%0d err", v), 64'(lr), 64'(VECS[v].expErr));
      end
    end

    // R2/R4: release at threshold, read threshold pacing
    cfgDropAll = 1'b0; cfgDropMask = '0;
    cfgRelThresh = 7'd3; cfgRdThresh = 7'd5;
    putWord(20, 0, 1, 0, 0);
    putWord(20, 1, 0, 0, 0);
    check(rdValid == 0, "R2 hidden before threshold", 64'(rdValid), 0);
    putWord(20, 2, 0, 0, 0);
    check(rdValid == 1, "R2 released at threshold", 64'(rdValid), 1);
    check(dmaReq == 0, "R4 below read threshold", 64'(dmaReq), 0);
    putWord(20, 3, 0, 0, 0);
    check(dmaReq == 0, "R4 four of five", 64'(dmaReq), 0);
    putWord(20, 4, 0, 0, 0);
    check(dmaReq == 1, "R4 at read threshold", 64'(dmaReq), 1);
    putWord(20, 5, 0, 1, 0);
    drain(20, n, le, lr, ok);
    check(n == 6 && ok, "R4 drain", 64'(n), 6);

    // R5: end flag overrides read threshold
    cfgRelThresh = 7'd1; cfgRdThresh = 7'd8;
    putWord(21, 0, 1, 0, 0);
    check(rdValid == 1 && dmaReq == 0, "R5 no end yet", 64'(dmaReq), 0);
    putWord(21, 1, 0, 1, 0);
    check(dmaReq == 1, "R5 end overrides", 64'(dmaReq), 1);

    // R12: stall holds data
    held = rdData;
    repeat (3) @(negedge clk);
    check(rdValid == 1 && rdData == held, "R12 stall hold", rdData, held);
    drain(21, n, le, lr, ok);
    check(n == 2 && ok && le, "R12 drain order", 64'(n), 2);

    // R13: stray word with no open packet
    putWord(22, 0, 0, 1, 4'b0001);
    check(errEvent == 0, "R13 no event", 64'(errEvent), 0);
    check(rdValid == 0, "R13 not stored", 64'(rdValid), 0);

    // R10: overflow of a hidden packet
    cfgRelThresh = 7'd100; cfgRdThresh = 7'd4;
    for (int i = 0; i < 64; i++) putWord(23, i, i == 0, 0, 0);
    check(rdValid == 0, "R10 still hidden", 64'(rdValid), 0);
    putWord(23, 64, 0, 0, 0);
    check(errEvent == 1, "R10 overflow event", 64'(errEvent), 1);
    check(rdValid == 0, "R10 dropped", 64'(rdValid), 0);
    cfgRelThresh = 7'd1;
    putWord(24, 0, 1, 0, 0);
    putWord(24, 1, 0, 1, 0);
    drain(24, n, le, lr, ok);
    check(n == 2 && ok && !lr, "R10 recovery", 64'(n), 2);

    // R11: overflow of a released packet truncates
    cfgRelThresh = 7'd2;
    for (int i = 0; i < 64; i++) putWord(25, i, i == 0, 0, 0);
    check(rdValid == 1 && errEvent == 0, "R11 full released", 64'(rdValid), 1);
    putWord(25, 64, 0, 0, 0);
    check(errEvent == 1, "R11 overflow event", 64'(errEvent), 1);
    putWord(25, 65, 0, 0, 0);
    putWord(25, 66, 0, 1, 0);
    check(errEvent == 0, "R11 trailing ignored", 64'(errEvent), 0);
    drain(25, n, le, lr, ok);
    check(n == 64, "R11 count", 64'(n), 64);
    check(ok, "R11 order", 64'(ok), 1);
    check(le == 1 && lr == 1, "R11 truncated end", {62'b0, le, lr}, 3);

    summary();
  end

endmodule